// File: doc/BRIEF.md
# Low-Power Entry and Wake Sequencer

This block decides when a clock controller drops into its low-power state and how it comes back out. Software sets an enable bit through a small register port; in the very next cycle the block gates the core clock and both peripheral bus clocks and turns off the three high-speed oscillators: the crystal, the 4 MHz RC and the 48 MHz RC. The low-speed sources are not driven by this block. An external wake event brings the block back. The block clears the enable bit and records the wake in a status flag. If the settle option is set, it also keeps the clocks gated while the oscillator that feeds the system clock stabilises.

The settle length depends on the system-clock source code that a neighbouring selector supplies. The delay counter advances only on `srcTick`, a one-cycle strobe taken from the selected source clock. The enable bit, the wake interrupt enable and the settle option accept writes only while the `unlocked` input is high. The status flag is cleared by writing 1 to it, and the interrupt line is the AND of the flag and its enable.

Top module: `pd_sequencer`

## Requirements
- R1: A write with `unlocked`=1 and `regWrData[0]`=1, made while running, sets `pdEnable`, and the clock enables go low on the next cycle. A wake event in the low-power state or during settling clears `pdEnable`.
- R2: In the low-power state, `hxtOn`, `mircOn` and `hircOn` are 0. They are 1 while running and while settling.
- R3: `coreClkEn`, `bus0ClkEn` and `bus1ClkEn` are 0 in the low-power state and during settling, for every `clkSel` value.
- R4: With `delayEn`=1, the clocks stay off for N `srcTick` strobes after the wake event. N is 4096 for `clkSel`=0 (crystal), 512 for `clkSel`=7 (48 MHz RC) and 32 for `clkSel`=5 (4 MHz RC). For any other code, N is 0.
- R5: A wake event in the low-power state or during settling sets `wakeFlag`. Writing `regWrData[3]`=1 clears it. A wake event while running has no effect.
- R6: `wakeIrq` is 1 exactly when both `wakeFlag` and `wakeIntEn` are 1.
- R7: `regWrData[0]` (enable), `regWrData[1]` (`wakeIntEn`) and `regWrData[2]` (`delayEn`) are ignored when `unlocked`=0.
- R8: With `delayEn`=0, or with a zero-length source, the clocks come back on in the cycle right after the wake event.
- R9: The settle counter advances only on cycles with `srcTick`=1. A wake event during settling restarts the count at the full length.
- R10: A wake event in the same cycle as a clearing write leaves `wakeFlag` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| unlocked | input | 1 | Protected bits may be written |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 4 | bit0 enable, bit1 wake irq enable, bit2 settle enable, bit3 flag clear |
| wakeEvent | input | 1 | Wake request from any source |
| clkSel | input | 3 | System clock source code |
| srcTick | input | 1 | One-cycle strobe from the selected source clock |
| pdEnable | output | 1 | Low-power enable bit |
| wakeIntEn | output | 1 | Wake interrupt enable bit |
| delayEn | output | 1 | Settle delay enable bit |
| wakeFlag | output | 1 | Wake status flag |
| wakeIrq | output | 1 | Wake interrupt |
| hxtOn | output | 1 | High-speed crystal enable |
| mircOn | output | 1 | 4 MHz RC enable |
| hircOn | output | 1 | 48 MHz RC enable |
| coreClkEn | output | 1 | Core clock gate |
| bus0ClkEn | output | 1 | Peripheral bus 0 clock gate |
| bus1ClkEn | output | 1 | Peripheral bus 1 clock gate |

## Verification
Two cases are hard to reach from the ports: a second wake that lands partway through settling, and a wake that arrives in the same cycle as a flag-clearing write. The bench produces the first by pulsing `wakeEvent` again a set number of cycles into the 4 MHz RC settle window. It then checks that the gated time equals the offset plus a full window. For the second, it drives the write strobe and the wake pulse on the same edge while the block is in the low-power state. A separate run with `srcTick` toggling on alternate cycles shows that the count follows the source strobe and not the control clock.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOWN   = 2'd1,
    ST_SETTLE = 2'd2
  } pdState_t;

  typedef struct packed {
    logic load;
    logic step;
  } delayCtl_t;

  localparam logic [2:0] SEL_XTAL_HI = 3'd0;
  localparam logic [2:0] SEL_RC_MID  = 3'd5;
  localparam logic [2:0] SEL_RC_HI   = 3'd7;

  localparam int WR_BIT_PD    = 0;
  localparam int WR_BIT_IEN   = 1;
  localparam int WR_BIT_DLY   = 2;
  localparam int WR_BIT_FCLR  = 3;
endpackage

// File: rtl/pdseq_delay.sv
module pdseq_delay
  import pdseq_pkg::*;
#(
  parameter int XTAL_CYC = 4096,
  parameter int RCHI_CYC = 512,
  parameter int RCMID_CYC = 32,
  localparam int CNT_W = $clog2(XTAL_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  delayCtl_t  ctl,
  input  logic [2:0] clkSel,
  output logic       zeroLen,
  output logic       lastTick
);
  logic [CNT_W-1:0] selLen;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    unique case (clkSel)
      SEL_XTAL_HI: selLen = CNT_W'(XTAL_CYC);
      SEL_RC_HI:   selLen = CNT_W'(RCHI_CYC);
      SEL_RC_MID:  selLen = CNT_W'(RCMID_CYC);
      default:     selLen = '0;
    endcase
  end

  assign zeroLen  = (selLen == '0);
  assign lastTick = ctl.step && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= selLen;
    end else if (ctl.step && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R4: a load brings in the length picked by the source code
  assert_load_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> cnt == $past(selLen));

  // R9: without a strobe or a load the count holds
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(cnt));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(XTAL_CYC));
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       unlocked,
  input  logic       regWrEn,
  input  logic [3:0] regWrData,
  input  logic       wakeEvent,
  input  logic       srcTick,
  input  logic       zeroLen,
  input  logic       lastTick,
  output delayCtl_t  ctl,
  output logic       pdEnable,
  output logic       wakeIntEn,
  output logic       delayEn,
  output logic       wakeFlag,
  output logic       wakeIrq,
  output logic       hxtOn,
  output logic       mircOn,
  output logic       hircOn,
  output logic       coreClkEn,
  output logic       bus0ClkEn,
  output logic       bus1ClkEn
);
  pdState_t state;
  logic wakeHit, protWr, clrWr, needSettle;

  assign wakeHit    = wakeEvent && (state != ST_RUN);
  assign protWr     = regWrEn && unlocked;
  assign clrWr      = regWrEn && regWrData[WR_BIT_FCLR];
  assign needSettle = delayEn && !zeroLen;

  assign ctl.load = wakeHit && needSettle;
  assign ctl.step = (state == ST_SETTLE) && srcTick && !wakeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      pdEnable  <= 1'b0;
      wakeIntEn <= 1'b0;
      delayEn   <= 1'b0;
      wakeFlag  <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (protWr && regWrData[WR_BIT_PD]) begin
            pdEnable <= 1'b1;
            state    <= ST_DOWN;
          end
        end
        ST_DOWN, ST_SETTLE: begin
          if (wakeHit) begin
            pdEnable <= 1'b0;
            state    <= needSettle ? ST_SETTLE : ST_RUN;
          end else if (state == ST_SETTLE && lastTick) begin
            state <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase

      if (protWr) begin
        wakeIntEn <= regWrData[WR_BIT_IEN];
        delayEn   <= regWrData[WR_BIT_DLY];
      end

      if (wakeHit)    wakeFlag <= 1'b1;
      else if (clrWr) wakeFlag <= 1'b0;
    end
  end

  assign wakeIrq   = wakeFlag && wakeIntEn;
  assign hxtOn     = (state != ST_DOWN);
  assign mircOn    = (state != ST_DOWN);
  assign hircOn    = (state != ST_DOWN);
  assign coreClkEn = (state == ST_RUN);
  assign bus0ClkEn = (state == ST_RUN);
  assign bus1ClkEn = (state == ST_RUN);

  // R1: a wake while down drops the enable and sets the flag
  assert_wake_clears_pd_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN && wakeEvent) |=> (!pdEnable && wakeFlag));

  // R7: a locked write leaves the protected option bits alone
  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked) |=> ($stable(wakeIntEn) && $stable(delayEn)));

  // R8: without a settle the clocks return in the next cycle
  assert_fast_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN && wakeEvent && !needSettle) |=> coreClkEn);

  // R10: a wake wins over a same-cycle clear
  assert_wake_beats_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wakeHit && clrWr) |=> wakeFlag);

  // R3: the gates close on the cycle after entry
  assert_gate_after_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && protWr && regWrData[WR_BIT_PD]) |=> (!coreClkEn && !bus0ClkEn && !bus1ClkEn));
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pdseq_pkg::*;
#(
  parameter int XTAL_CYC = 4096,
  parameter int RCHI_CYC = 512,
  parameter int RCMID_CYC = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       unlocked,
  input  logic       regWrEn,
  input  logic [3:0] regWrData,
  input  logic       wakeEvent,
  input  logic [2:0] clkSel,
  input  logic       srcTick,
  output logic       pdEnable,
  output logic       wakeIntEn,
  output logic       delayEn,
  output logic       wakeFlag,
  output logic       wakeIrq,
  output logic       hxtOn,
  output logic       mircOn,
  output logic       hircOn,
  output logic       coreClkEn,
  output logic       bus0ClkEn,
  output logic       bus1ClkEn
);
  delayCtl_t ctl;
  logic zeroLen, lastTick;

  pdseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .unlocked(unlocked), .regWrEn(regWrEn),
    .regWrData(regWrData), .wakeEvent(wakeEvent), .srcTick(srcTick),
    .zeroLen(zeroLen), .lastTick(lastTick), .ctl(ctl),
    .pdEnable(pdEnable), .wakeIntEn(wakeIntEn), .delayEn(delayEn),
    .wakeFlag(wakeFlag), .wakeIrq(wakeIrq), .hxtOn(hxtOn),
    .mircOn(mircOn), .hircOn(hircOn), .coreClkEn(coreClkEn),
    .bus0ClkEn(bus0ClkEn), .bus1ClkEn(bus1ClkEn)
  );

  pdseq_delay #(
    .XTAL_CYC(XTAL_CYC), .RCHI_CYC(RCHI_CYC), .RCMID_CYC(RCMID_CYC)
  ) u_delay (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clkSel(clkSel),
    .zeroLen(zeroLen), .lastTick(lastTick)
  );
endmodule

// File: tb/sim_pd_sequencer.sv
`timescale 1ns/1ps
module sim_pd_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic unlocked = 1'b0, regWrEn = 1'b0, wakeEvent = 1'b0, srcTick = 1'b1;
  logic [3:0] regWrData = '0;
  logic [2:0] clkSel = '0;
  logic pdEnable, wakeIntEn, delayEn, wakeFlag, wakeIrq;
  logic hxtOn, mircOn, hircOn, coreClkEn, bus0ClkEn, bus1ClkEn;

  int checks = 0;
  int fails = 0;
  bit toggleTick = 1'b0;

  always #2.5 clk = ~clk;

  pd_sequencer u0 (
    .clk(clk), .rstN(rstN), .unlocked(unlocked), .regWrEn(regWrEn),
    .regWrData(regWrData), .wakeEvent(wakeEvent), .clkSel(clkSel),
    .srcTick(srcTick), .pdEnable(pdEnable), .wakeIntEn(wakeIntEn),
    .delayEn(delayEn), .wakeFlag(wakeFlag), .wakeIrq(wakeIrq),
    .hxtOn(hxtOn), .mircOn(mircOn), .hircOn(hircOn),
    .coreClkEn(coreClkEn), .bus0ClkEn(bus0ClkEn), .bus1ClkEn(bus1ClkEn)
  );

  always @(negedge clk) if (toggleTick) srcTick <= ~srcTick;

  // entry: {clkSel, delayEn, expected gated cycles}
  typedef struct packed {
    logic [2:0] sel;
    logic       dly;
    int         expOff;
  } vec_t;
  localparam vec_t VECS [7] = '{
    '{3'd0, 1'b1, 4096},
    '{3'd7, 1'b1, 512},
    '{3'd5, 1'b1, 32},
    '{3'd1, 1'b1, 0},
    '{3'd3, 1'b1, 0},
    '{3'd0, 1'b0, 0},
    '{3'd7, 1'b0, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d, input logic unl);
    regWrData = d; unlocked = unl; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; unlocked = 1'b0; regWrData = '0;
  endtask

  task automatic wake();
    wakeEvent = 1'b1;
    @(negedge clk);
    wakeEvent = 1'b0;
  endtask

  task automatic countOff(output int n);
    n = 0;
    while (!coreClkEn && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state R1 R3 R6
    check(!pdEnable && !wakeFlag && !wakeIrq && !delayEn && !wakeIntEn, "R1 reset bits", pdEnable, 0);
    check(coreClkEn && bus0ClkEn && bus1ClkEn && hxtOn, "R3 reset clocks on", coreClkEn, 1);

    // R7 locked write has no effect
    wr(4'b0111, 1'b0);
    check(!pdEnable && coreClkEn, "R7 locked enable", pdEnable, 0);
    check(!wakeIntEn && !delayEn, "R7 locked options", {wakeIntEn, delayEn}, 0);

    // R5 wake while running has no effect
    wake();
    check(!wakeFlag, "R5 wake while running", wakeFlag, 0);

    // table walk R4 R8 R3 R2 R1
    foreach (VECS[i]) begin
      clkSel = VECS[i].sel;
      wr({1'b1, VECS[i].dly, 1'b0, 1'b0}, 1'b1);
      wr({1'b0, VECS[i].dly, 1'b0, 1'b1}, 1'b1);
      check(pdEnable && !coreClkEn && !bus0ClkEn && !bus1ClkEn, "R3 gated when down", coreClkEn, 0);
      check(!hxtOn && !mircOn && !hircOn, "R2 oscillators off", {hxtOn, mircOn, hircOn}, 0);
      wake();
      check(!pdEnable && wakeFlag, "R1 enable auto-clears", pdEnable, 0);
      if (VECS[i].expOff > 0)
        check(hxtOn && mircOn && hircOn, "R2 oscillators on while settling", {hxtOn, mircOn, hircOn}, 7);
      countOff(n);
      check(n == VECS[i].expOff, VECS[i].dly ? "R4 settle length" : "R8 no settle", n, VECS[i].expOff);
    end

    // R6 interrupt needs flag and enable; R5 clear
    wr(4'b0000, 1'b1);
    check(wakeFlag && !wakeIrq, "R6 irq masked", wakeIrq, 0);
    wr(4'b0010, 1'b1);
    check(wakeIrq, "R6 irq asserted", wakeIrq, 1);
    wr(4'b1010, 1'b0);
    check(!wakeFlag && !wakeIrq && wakeIntEn, "R5 write-one clears flag", wakeFlag, 0);

    // R10 wake coinciding with clear
    wr(4'b0011, 1'b1);
    regWrData = 4'b1010; unlocked = 1'b1; regWrEn = 1'b1; wakeEvent = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; unlocked = 1'b0; wakeEvent = 1'b0; regWrData = '0;
    check(wakeFlag, "R10 wake beats clear", wakeFlag, 1);
    wr(4'b1000, 1'b0);

    // R9 restart during settle, 4 MHz RC
    clkSel = 3'd5;
    wr(4'b0101, 1'b1);
    wake();
    repeat (9) @(negedge clk);
    wake();
    countOff(n);
    check(n == 32, "R9 restart full window", n + 10, 42);

    // R9 count follows srcTick at half rate
    wr(4'b0101, 1'b1);
    srcTick = 1'b0;
    toggleTick = 1'b1;
    wake();
    countOff(n);
    toggleTick = 1'b0;
    check(n >= 63 && n <= 64, "R9 advances on srcTick only", n, 64);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule